// File: doc/BRIEF.md
# SPI Message Engine with Prepend Phase

This block is a single-controller SPI command engine. Software fills a transmit buffer, sets the clock rate and SPI mode, writes a message-control word (main-phase byte count and transfer type), then writes a command word. The command word carries an opcode, a prepend byte count and a target select. The engine then runs one message with chip select held low from start to finish. The message has an optional write-only prepend phase followed by the main phase, which is full-duplex, read-only or write-only. Words are always 8 bits, sent MSB first.

Received main-phase bytes go into a receive buffer starting at offset 0. A tail counter reports how many bytes were stored. When the message ends, chip select rises and a done status bit is set. That bit drives the interrupt output through a mask bit. The transmit and receive buffers are inferred RAMs inside the block, read and written through the same word-wide register port.

Address map (9-bit word address): 0 message control, 1 command, 2 clock config, 3 status, 4 interrupt mask, 5 receive tail. A write to 0x100+i stores transmit byte i. A read of 0x080+i returns receive byte i.

Top module: `spi_msg_engine`

## Requirements
- R1: After reset, every chip-select line is high, sclk_o is 0, irq_o is 0, and status (addr 3) and receive tail (addr 5) both read 0.
- R2: Clock config (addr 2) bit 4 sets the sclk_o idle level. Bit 5 set makes data change on the leading edge and get sampled on the trailing edge; bit 5 clear makes it sampled on the leading edge. Full-duplex data is exchanged correctly in all four combinations.
- R3: A full-duplex message (message control bits [9:8] = 0, byte count in bits [7:0]) sends that many bytes from transmit offset 0. It stores every byte received on miso_i into the receive buffer from offset 0, and the tail ends equal to the count.
- R4: A read-only message (bits [9:8] = 1) stores the count of received bytes with the tail equal to the count. Every bit the target samples on mosi_o during the main phase is 0.
- R5: A write-only message (bits [9:8] = 2 or 3) sends the count of bytes, ignores miso_i, leaves the tail at 0 and leaves the receive buffer unchanged.
- R6: Command bits [7:4] give a prepend count P of 0 to 15. The first P transmit bytes are sent before the main phase and are never captured. The main phase continues at transmit offset P and stores from receive offset 0. Chip select falls exactly once for the whole message.
- R7: Command bits [10:8] select which single cs_n_o line goes low while the message runs. All lines return high when it ends.
- R8: At the end of a message, status bit 0 (done) is set, and irq_o equals done AND mask bit 0 (addr 4). Writing 16'h00FF to status clears done and the error bit. Any other value written to status has no effect.
- R9: Clock config bits [2:0] = s give an sclk_o half period of 2^s clock cycles for s from 0 to 6. The value 7 behaves like 6, so there are seven rates, each half the previous one.
- R10: A main-phase byte count above DEPTH is clamped to DEPTH bytes and sets sticky status bit 2.
- R11: Status bit 1 (busy) is high from an accepted command until done. Only opcode 1 in command bits [1:0] starts a message. A command written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register/buffer write strobe |
| addr_i | input | 9 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Masked done interrupt |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Active-low chip selects |

## Verification
The assertions assume that clock config (rate and mode bits) and message control stay unchanged while busy is high. The sclk idle check and the byte-framing checks depend on that. The stimulus writes those registers only between messages, after polling done. It also resets the bench's target model whenever chip select falls. The bench's own target model shifts on the edges that the mode under test defines, so mode errors show up as wrong data rather than being hidden by a loopback.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
  typedef enum logic [1:0] {MT_FDX = 2'd0, MT_HRD = 2'd1, MT_HWR = 2'd2, MT_HWR2 = 2'd3} msg_type_e;
  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_WAIT} seq_state_e;
  localparam logic [2:0]  A_MSG = 3'd0, A_CMD = 3'd1, A_CLK = 3'd2,
                          A_STAT = 3'd3, A_MASK = 3'd4, A_TAIL = 3'd5;
  localparam logic [1:0]  OP_START = 2'b01;
  localparam logic [15:0] CLR_ALL  = 16'h00FF;
  localparam int          PRE_MAX  = 15;
  localparam int          RATE_TOP = 6;
endpackage

// File: rtl/spi_msg_rate.sv
module spi_msg_rate #(
  parameter int HALF_MIN = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int CW = $clog2(HALF_MIN * (1 << spi_msg_pkg::RATE_TOP) + 1);

  logic [CW-1:0] cnt_q, half;
  logic [2:0]    sel_c;

  always_comb begin
    sel_c  = (sel_i > 3'(spi_msg_pkg::RATE_TOP)) ? 3'(spi_msg_pkg::RATE_TOP) : sel_i;
    half   = CW'(HALF_MIN) << sel_c;
    tick_o = en_i && (cnt_q == half - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_msg_shift.sv
module spi_msg_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpol_i,
  input  logic       cpha_i,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       active_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  logic [3:0] edge_q;
  logic       active_q, sclk_q, mosi_q, done_q;
  logic [7:0] tx_sr, rx_sr;
  logic       smp_edge;

  // even edge count = leading edge; sample on leading when cpha=0
  assign smp_edge = ~edge_q[0] ^ cpha_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0; active_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      done_q <= 1'b0; tx_sr <= '0; rx_sr <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        if (!cpha_i) begin
          mosi_q <= tx_byte_i[7];
          tx_sr  <= {tx_byte_i[6:0], 1'b0};
        end else begin
          tx_sr  <= tx_byte_i;
        end
      end else if (active_q && tick_i) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 4'd1;
        if (smp_edge) begin
          rx_sr <= {rx_sr[6:0], miso_i};
        end else if (cpha_i || edge_q != 4'd15) begin
          mosi_q <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
        end
        if (edge_q == 4'd15) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else if (!active_q) begin
        sclk_q <= cpol_i;
      end
    end
  end

  assign active_o  = active_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_sr;

  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (sclk_q == cpol_i));
endmodule

// File: rtl/spi_msg_buf.sv
module spi_msg_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = (32'(raddr_i) < DEPTH) ? mem[raddr_i] : 8'h00;
endmodule

// File: rtl/spi_msg_engine.sv
module spi_msg_engine
  import spi_msg_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int NUM_CS   = 8,
  parameter int HALF_MIN = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [8:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  localparam int TX_DEPTH = DEPTH + PRE_MAX;
  localparam int TXA_W    = $clog2(TX_DEPTH);
  localparam int RXA_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int ID_W     = $clog2(NUM_CS);

  logic [7:0]        msg_cnt_q;
  msg_type_e         msg_type_q;
  logic [15:0]       cmd_q;
  logic [2:0]        rate_q;
  logic              cpol_q, cpha_q, mask_q, done_q, err_q, in_pre_q;
  seq_state_e        state_q;
  logic [3:0]        pre_left_q;
  logic [CNT_W-1:0]  main_left_q, tail_q;
  logic [TXA_W-1:0]  tx_idx_q;
  logic [NUM_CS-1:0] cs_n_q;

  logic reg_wr, cmd_wr, busy, start, over, byte_start, byte_done, tick, active, rx_we;
  logic [7:0] tx_rd, rx_rd, tx_byte, rx_byte;

  assign reg_wr = wr_en_i && (addr_i[8:7] == 2'b00);
  assign cmd_wr = reg_wr && (addr_i[2:0] == A_CMD);
  assign busy   = (state_q != S_IDLE);
  assign start  = cmd_wr && !busy && (wdata_i[1:0] == OP_START);
  assign over   = msg_cnt_q > 8'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_cnt_q <= '0; msg_type_q <= MT_FDX; cmd_q <= '0;
      rate_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; mask_q <= 1'b0;
    end else if (reg_wr) begin
      case (addr_i[2:0])
        A_MSG:  begin msg_cnt_q <= wdata_i[7:0]; msg_type_q <= msg_type_e'(wdata_i[9:8]); end
        A_CMD:  if (!busy) cmd_q <= wdata_i;
        A_CLK:  begin rate_q <= wdata_i[2:0]; cpol_q <= wdata_i[4]; cpha_q <= wdata_i[5]; end
        A_MASK: mask_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // message sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; pre_left_q <= '0; main_left_q <= '0; tail_q <= '0;
      tx_idx_q <= '0; in_pre_q <= 1'b0; cs_n_q <= '1; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (reg_wr && addr_i[2:0] == A_STAT && wdata_i == CLR_ALL) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      case (state_q)
        S_IDLE: if (start) begin
          state_q     <= S_NEXT;
          pre_left_q  <= wdata_i[7:4];
          main_left_q <= over ? CNT_W'(DEPTH) : CNT_W'(msg_cnt_q);
          tx_idx_q    <= '0;
          tail_q      <= '0;
          cs_n_q      <= ~(NUM_CS'(1) << wdata_i[8 +: ID_W]);
          if (over) err_q <= 1'b1;
        end
        S_NEXT: begin
          if (pre_left_q != 4'd0) begin
            in_pre_q   <= 1'b1;
            pre_left_q <= pre_left_q - 4'd1;
            state_q    <= S_WAIT;
          end else if (main_left_q != '0) begin
            in_pre_q    <= 1'b0;
            main_left_q <= main_left_q - CNT_W'(1);
            state_q     <= S_WAIT;
          end else begin
            cs_n_q  <= '1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WAIT: if (byte_done) begin
          tx_idx_q <= tx_idx_q + TXA_W'(1);
          if (rx_we) tail_q <= tail_q + CNT_W'(1);
          state_q <= S_NEXT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign byte_start = (state_q == S_NEXT) && (pre_left_q != 4'd0 || main_left_q != '0);
  assign tx_byte    = (pre_left_q == 4'd0 && msg_type_q == MT_HRD) ? 8'h00 : tx_rd;
  assign rx_we      = (state_q == S_WAIT) && byte_done && !in_pre_q && !msg_type_q[1];

  spi_msg_buf #(.DEPTH(TX_DEPTH), .AW(TXA_W)) u_txbuf (
    .clk_i(clk_i), .we_i(wr_en_i && addr_i[8]), .waddr_i(addr_i[TXA_W-1:0]),
    .wdata_i(wdata_i[7:0]), .raddr_i(tx_idx_q), .rdata_o(tx_rd));

  spi_msg_buf #(.DEPTH(DEPTH), .AW(RXA_W)) u_rxbuf (
    .clk_i(clk_i), .we_i(rx_we), .waddr_i(tail_q[RXA_W-1:0]),
    .wdata_i(rx_byte), .raddr_i(addr_i[RXA_W-1:0]), .rdata_o(rx_rd));

  spi_msg_rate #(.HALF_MIN(HALF_MIN)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(active), .sel_i(rate_q), .tick_o(tick));

  spi_msg_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol_q), .cpha_i(cpha_q), .tick_i(tick),
    .start_i(byte_start), .tx_byte_i(tx_byte), .miso_i(miso_i), .active_o(active),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(byte_done), .rx_byte_o(rx_byte));

  always_comb begin
    rdata_o = '0;
    if (addr_i[8])      rdata_o = '0;
    else if (addr_i[7]) rdata_o = {8'h00, rx_rd};
    else begin
      case (addr_i[2:0])
        A_MSG:  rdata_o = {6'b0, msg_type_q, msg_cnt_q};
        A_CMD:  rdata_o = cmd_q;
        A_CLK:  rdata_o = {10'b0, cpha_q, cpol_q, 1'b0, rate_q};
        A_STAT: rdata_o = {13'b0, err_q, busy, done_q};
        A_MASK: rdata_o = {15'b0, mask_q};
        A_TAIL: rdata_o = 16'(tail_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o  = done_q & mask_q;
  assign cs_n_o = cs_n_q;

  // R7
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_q));
  // R6
  pre_nocap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pre_q && byte_done) |=> $stable(tail_q));
  // R11
  busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && cmd_wr) |=> $stable(cs_n_q));
  // R10
  tail_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q <= CNT_W'(DEPTH));
  // R8
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q);
endmodule

// File: tb/tb_spi_msg_engine.sv
module tb_spi_msg_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [8:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, sclk, mosi, miso = 1'b0;
  logic [7:0] cs_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txb [128];
  logic [7:0] s_mosi [128];
  int s_nrx = 0, s_ntx = 0, s_scnt = 0, cs_falls = 0;
  logic [7:0] s_sh = '0, s_rx = '0;
  logic s_cpol = 1'b0, s_cpha = 1'b0, cs_prev = 1'b1;
  logic [7:0] cs_seen;

  always #4 clk = ~clk;

  spi_msg_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n));

  function automatic logic [7:0] mpat(int n);
    return 8'(8'h3C + n * 17);
  endfunction

  // target model
  always @(sclk, cs_n) begin
    logic cs_all, lead;
    cs_all = &cs_n;
    if (cs_all !== cs_prev) begin
      if (cs_all === 1'b0) begin
        cs_falls++; s_nrx = 0; s_scnt = 0; s_ntx = 0;
        if (!s_cpha) begin s_sh = mpat(0); miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; s_ntx = 1; end
      end
      cs_prev = cs_all;
    end else if (cs_all === 1'b0) begin
      lead = (sclk != s_cpol);
      if (lead ^ s_cpha) begin
        s_rx = {s_rx[6:0], mosi}; s_scnt++;
        if (s_scnt == 8) begin s_mosi[s_nrx] = s_rx; s_nrx++; s_scnt = 0; end
      end else begin
        if (s_scnt == 0) begin s_sh = mpat(s_ntx); s_ntx++; end
        miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0};
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic set_mode(int rate, logic pol, logic pha);
    wr(9'd2, 16'((pha << 5) | (pol << 4) | rate));
    s_cpol = pol; s_cpha = pha;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_tx(int n, int seed);
    for (int i = 0; i < n; i++) begin
      txb[i] = 8'(seed + i * 29 + 1);
      wr(9'h100 + 9'(i), {8'h00, txb[i]});
    end
  endtask

  task automatic wait_done();
    logic [15:0] st;
    for (int i = 0; i < 40000; i++) begin
      rd(9'd3, st);
      if (st[0]) break;
    end
  endtask

  task automatic run(int typ, int cnt, int pre, int id);
    wr(9'd0, 16'((typ << 8) | cnt));
    wr(9'd1, 16'((id << 8) | (pre << 4) | 1));
    @(negedge clk); cs_seen = cs_n;
    wait_done();
  endtask

  task automatic clr();
    wr(9'd3, 16'h00FF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 cs", 32'(cs_n), 32'hFF);
    check("R1 sclk", 32'(sclk), 0);
    check("R1 irq", 32'(irq), 0);
    rd(9'd3, d); check("R1 status", 32'(d), 0);
    rd(9'd5, d); check("R1 tail", 32'(d), 0);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    for (int m = 0; m < 4; m++) begin
      int bad = 0;
      set_mode(0, 1'(m >> 1), 1'(m & 1));
      load_tx(5, m * 40);
      run(0, 5, 0, 0);
      check("R3 mosi count", 32'(s_nrx), 5);
      for (int i = 0; i < 5; i++) if (s_mosi[i] !== txb[i]) bad++;
      check("R2 R3 mosi data", 32'(bad), 0);
      bad = 0;
      for (int i = 0; i < 5; i++) begin rd(9'h080 + 9'(i), d); if (d[7:0] !== mpat(i)) bad++; end
      check("R2 R3 rx data", 32'(bad), 0);
      rd(9'd5, d); check("R3 tail", 32'(d), 5);
      check("R2 sclk idle", 32'(sclk), 32'(m >> 1));
      clr();
    end
    set_mode(0, 1'b0, 1'b0);
  endtask

  task automatic t_prepend();
    logic [15:0] d;
    int bad = 0, f0;
    load_tx(7, 90);
    f0 = cs_falls;
    run(0, 4, 3, 0);
    check("R6 single cs frame", 32'(cs_falls - f0), 1);
    check("R6 bytes sent", 32'(s_nrx), 7);
    for (int i = 0; i < 7; i++) if (s_mosi[i] !== txb[i]) bad++;
    check("R6 tx order", 32'(bad), 0);
    bad = 0;
    for (int i = 0; i < 4; i++) begin rd(9'h080 + 9'(i), d); if (d[7:0] !== mpat(3 + i)) bad++; end
    check("R6 rx skips prepend", 32'(bad), 0);
    rd(9'd5, d); check("R6 tail", 32'(d), 4);
    clr();
  endtask

  task automatic t_write();
    logic [15:0] d;
    int bad = 0;
    load_tx(3, 7);
    run(2, 3, 0, 0);
    for (int i = 0; i < 3; i++) if (s_mosi[i] !== txb[i]) bad++;
    check("R5 tx data", 32'(bad), 0);
    rd(9'd5, d); check("R5 tail", 32'(d), 0);
    rd(9'h080, d); check("R5 rx untouched", 32'(d), 32'(mpat(3)));
    clr();
  endtask

  task automatic t_read();
    logic [15:0] d;
    int bad = 0;
    load_tx(4, 200);
    run(1, 4, 0, 0);
    for (int i = 0; i < 4; i++) if (s_mosi[i] !== 8'h00) bad++;
    check("R4 mosi low", 32'(bad), 0);
    bad = 0;
    for (int i = 0; i < 4; i++) begin rd(9'h080 + 9'(i), d); if (d[7:0] !== mpat(i)) bad++; end
    check("R4 rx data", 32'(bad), 0);
    rd(9'd5, d); check("R4 tail", 32'(d), 4);
    clr();
  endtask

  task automatic t_devid();
    run(0, 1, 0, 5);
    check("R7 cs during msg", 32'(cs_seen), 32'h DF);
    check("R7 cs after msg", 32'(cs_n), 32'hFF);
    clr();
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(9'd4, 16'h0000);
    run(0, 1, 0, 0);
    check("R8 irq masked", 32'(irq), 0);
    wr(9'd4, 16'h0001); @(negedge clk);
    check("R8 irq enabled", 32'(irq), 1);
    wr(9'd3, 16'h0001);
    rd(9'd3, d); check("R8 other value ignored", 32'(d[0]), 1);
    clr();
    rd(9'd3, d); check("R8 clear all", 32'(d), 0);
    check("R8 irq low", 32'(irq), 0);
    wr(9'd4, 16'h0000);
  endtask

  task automatic t_rate(int sel, int exp);
    int n = 0;
    set_mode(sel, 1'b0, 1'b0);
    wr(9'd0, 16'd1);
    wr(9'd1, 16'h0001);
    while (!sclk) @(negedge clk);
    while (sclk) begin @(negedge clk); n++; end
    check($sformatf("R9 half period sel %0d", sel), 32'(n), 32'(exp));
    wait_done();
    clr();
    set_mode(0, 1'b0, 1'b0);
  endtask

  task automatic t_clamp();
    logic [15:0] d;
    load_tx(64, 3);
    run(0, 100, 0, 0);
    check("R10 bytes sent", 32'(s_nrx), 64);
    rd(9'd5, d); check("R10 tail", 32'(d), 64);
    rd(9'd3, d); check("R10 err bit", 32'(d[2]), 1);
    clr();
    rd(9'd3, d); check("R10 err cleared", 32'(d), 0);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    load_tx(3, 11);
    wr(9'd1, 16'h0002);
    repeat (3) @(negedge clk);
    rd(9'd3, d); check("R11 bad opcode no start", 32'(d[1]), 0);
    wr(9'd0, 16'd3);
    wr(9'd1, 16'h0101);
    rd(9'd3, d); check("R11 busy", 32'(d[1]), 1);
    wr(9'd1, 16'h0201);
    @(negedge clk);
    check("R11 cs unchanged", 32'(cs_n), 32'hFD);
    wait_done();
    repeat (4) @(negedge clk);
    rd(9'd3, d); check("R11 idle after", 32'(d[1]), 0);
    check("R11 only first message", 32'(s_nrx), 3);
    clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_prepend();
    t_write();
    t_read();
    t_devid();
    t_irq();
    t_rate(2, 4);
    t_rate(7, 64);
    t_clamp();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule